// File: doc/BRIEF.md
# Dithered-Fraction PWM DAC Bank

This block drives a bank of slow, high-resolution DAC outputs. Each output is a PWM pulse train meant to be smoothed by an external RC filter. All channels share one free-running period counter of 2^COARSE_W clocks. Each channel holds a setpoint of COARSE_W + FRAC_W bits. The upper field sets the pulse width in whole clocks. The lower field is a fraction. A first-order error-feedback accumulator spreads that fraction over successive periods by sometimes lengthening the pulse by one clock. Because of this, the filtered average carries the full setpoint resolution rather than only the coarse part.

Software writes a setpoint through a simple strobe port that carries a channel index and a value. The write lands in a per-channel shadow register. The channel samples the shadow only at the period boundary, so a write never cuts a pulse short or stretches it. A global enable starts the period timer. When the enable is dropped, the timer is parked, the accumulators are cleared and every output is forced low. Each output leaves the block through a flip-flop on the fast clock, so its edges are tied to the clock.

Top module: `dsx_pwm_dac`

## Requirements
- R1: While reset is asserted and after it is released, every `pwm_o` bit is 0, and every setpoint register reads as 0 until it is written.
- R2: A period is 2^COARSE_W clocks. In every period, a channel's output is high for exactly W consecutive clocks, starting at the first clock of the period, where W is that period's effective width.
- R3: A setpoint is split into two fields: bits [COARSE_W+FRAC_W-1:FRAC_W] are the coarse width C, and bits [FRAC_W-1:0] are the fraction F. At each boundary, F is added to an FRAC_W-bit accumulator. The effective width is C+1 if that add carries out and C otherwise. The accumulator keeps the sum modulo 2^FRAC_W. Example: with COARSE_W=4 and FRAC_W=8, setpoint 0x280 gives widths 2,3,2,3 in the first four periods after enable.
- R4: With a constant setpoint S written before enable, the total high time over the first 2^FRAC_W periods after enable is exactly S clocks.
- R5: A setpoint of 0 keeps the output constantly low.
- R6: When C is 2^COARSE_W-1 and the add carries, the width saturates at 2^COARSE_W, so the output is high for the whole period.
- R7: A setpoint write made in the middle of a period leaves that period's pulse unchanged and takes effect from the next period boundary.
- R8: With `en_i` low, every output is low within two clocks, the period counter is parked, and the accumulators are cleared, so the next enable starts with an accumulator of 0.
- R9: The output is registered: it rises only one clock after the counter was 0, and falls one clock after the counter equalled the width.
- R10: A write changes only the channel named by `wr_ch_i`; the pulses of the other channels are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PWM count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global run enable for the period timer and all channels |
| wr_en_i | input | 1 | Setpoint write strobe, one clock per write |
| wr_ch_i | input | CH_W | Channel index of the write |
| wr_data_i | input | COARSE_W+FRAC_W | Setpoint value: coarse field above, fraction field below |
| pwm_o | output | NUM_CH | Registered PWM output, one bit per channel |

## Verification
The first clock edge with the enable high is the period boundary: it zeroes the counter and loads each channel's width. The pins show the pulse of counter value c one edge later, so the bench starts its sample index two edges after it raises the enable. From there, sample s belongs to period s / 2^COARSE_W and to count s mod 2^COARSE_W. A write strobed at sample k is captured at the next edge, and its effect is expected only in the samples of the following period. After the enable drops, the outputs are checked two edges later. All samples are taken on the falling clock edge.

// File: rtl/dsx_pwm_pkg.sv
package dsx_pwm_pkg;

   // index width that stays legal for a single-entry range
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dsx_period_timer.sv
module dsx_period_timer #(
   parameter int COARSE_W = 14
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                en_i,
   output logic [COARSE_W-1:0] cnt_o,
   output logic                tick_o
);
   localparam logic [COARSE_W-1:0] CNT_LAST = {COARSE_W{1'b1}};

   logic [COARSE_W-1:0] cnt_q;

   // parked on the last count so the first enabled edge is a boundary
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= CNT_LAST;
      else if (!en_i) cnt_q <= CNT_LAST;
      else            cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign tick_o = en_i && (cnt_q == CNT_LAST);
endmodule

// File: rtl/dsx_channel.sv
module dsx_channel #(
   parameter int COARSE_W = 14,
   parameter int FRAC_W   = 8,
   parameter int SP_W     = COARSE_W + FRAC_W
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                en_i,
   input  logic                tick_i,
   input  logic                wr_i,
   input  logic [SP_W-1:0]     data_i,
   input  logic [COARSE_W-1:0] cnt_i,
   output logic                pwm_o,
   output logic [COARSE_W:0]   width_o
);
   logic [SP_W-1:0]     shadow_q;
   logic [COARSE_W-1:0] coarse;
   logic                carry;
   logic [COARSE_W:0]   width_q;
   logic                raw;
   logic                pwm_q;

   if (SP_W != COARSE_W + FRAC_W) begin : g_bad_sp
      $error("SP_W must equal COARSE_W + FRAC_W");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   shadow_q <= '0;
      else if (wr_i) shadow_q <= data_i;
   end

   assign coarse = shadow_q[SP_W-1:FRAC_W];

   if (FRAC_W > 0) begin : g_dither
      logic [FRAC_W-1:0] acc_q;
      logic [FRAC_W:0]   acc_sum;

      assign acc_sum = {1'b0, acc_q} + {1'b0, shadow_q[FRAC_W-1:0]};
      assign carry   = acc_sum[FRAC_W];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     acc_q <= '0;
         else if (!en_i)  acc_q <= '0;
         else if (tick_i) acc_q <= acc_sum[FRAC_W-1:0];
      end
   end else begin : g_plain
      assign carry = 1'b0;
   end

   // one extra bit so full-period saturation fits
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     width_q <= '0;
      else if (!en_i)  width_q <= '0;
      else if (tick_i) width_q <= {1'b0, coarse} + (COARSE_W+1)'(carry);
   end

   assign raw = ({1'b0, cnt_i} < width_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pwm_q <= 1'b0;
      else         pwm_q <= raw;
   end

   assign pwm_o   = pwm_q;
   assign width_o = width_q;
endmodule

// File: rtl/dsx_pwm_dac.sv
module dsx_pwm_dac #(
   parameter int NUM_CH   = 10,
   parameter int COARSE_W = 14,
   parameter int FRAC_W   = 8,
   parameter int SP_W     = COARSE_W + FRAC_W,
   parameter int CH_W     = dsx_pwm_pkg::idx_width(NUM_CH)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              wr_en_i,
   input  logic [CH_W-1:0]   wr_ch_i,
   input  logic [SP_W-1:0]   wr_data_i,
   output logic [NUM_CH-1:0] pwm_o
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (COARSE_W < 2) begin : g_bad_cw
      $error("COARSE_W must be at least 2");
   end
   if (FRAC_W < 0) begin : g_bad_fw
      $error("FRAC_W must not be negative");
   end
   if ((1 << CH_W) < NUM_CH) begin : g_bad_idx
      $error("CH_W too narrow for NUM_CH");
   end

   logic [COARSE_W-1:0]             cnt;
   logic                            tick;
   logic [NUM_CH-1:0][COARSE_W:0]   width_all;

   dsx_period_timer #(.COARSE_W(COARSE_W)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .cnt_o  (cnt),
      .tick_o (tick)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel;
      assign sel = wr_en_i && (wr_ch_i == CH_W'(i));

      dsx_channel #(
         .COARSE_W (COARSE_W),
         .FRAC_W   (FRAC_W),
         .SP_W     (SP_W)
      ) u_ch (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .en_i    (en_i),
         .tick_i  (tick),
         .wr_i    (sel),
         .data_i  (wr_data_i),
         .cnt_i   (cnt),
         .pwm_o   (pwm_o[i]),
         .width_o (width_all[i])
      );
   end
endmodule

// File: rtl/dsx_pwm_dac_chk.sv
module dsx_pwm_dac_chk #(
   parameter int NUM_CH   = 10,
   parameter int COARSE_W = 14
) (
   input logic                            clk_i,
   input logic                            rst_ni,
   input logic                            en_i,
   input logic                            tick,
   input logic [COARSE_W-1:0]             cnt,
   input logic [NUM_CH-1:0][COARSE_W:0]   width_all,
   input logic [NUM_CH-1:0]               pwm_o
);
   // R8
   disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(en_i) && !$past(en_i, 2)) |-> (pwm_o == '0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
      // R9
      rise_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(pwm_o[i]) |-> ($past(cnt) == '0));

      // R2
      fall_at_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($fell(pwm_o[i]) && $past(en_i, 2))
         |-> ({1'b0, $past(cnt)} == $past(width_all[i])));

      // R7
      width_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (en_i && !tick) |=> $stable(width_all[i]));
   end
endmodule

bind dsx_pwm_dac dsx_pwm_dac_chk #(
   .NUM_CH   (NUM_CH),
   .COARSE_W (COARSE_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .en_i      (en_i),
   .tick      (tick),
   .cnt       (cnt),
   .width_all (width_all),
   .pwm_o     (pwm_o)
);

// File: tb/dsx_pwm_dac_tb.sv
`timescale 1ns/1ps
module dsx_pwm_dac_tb;
   localparam int NUM_CH   = 10;
   localparam int COARSE_W = 4;
   localparam int FRAC_W   = 8;
   localparam int SP_W     = COARSE_W + FRAC_W;
   localparam int CH_W     = 4;
   localparam int PER      = 1 << COARSE_W;
   localparam int NPER     = 1 << FRAC_W;

   localparam logic [SP_W-1:0] VEC [NUM_CH] = '{
      12'h000, 12'h500, 12'h280, 12'hFFF, 12'h001,
      12'hF01, 12'h0FF, 12'h7FF, 12'hA5A, 12'h100 };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic              wr_en = 1'b0;
   logic [CH_W-1:0]   wr_ch = '0;
   logic [SP_W-1:0]   wr_data = '0;
   logic [NUM_CH-1:0] pwm;

   int applied = 0;
   int miscompares = 0;
   bit done = 0;

   int sums [NUM_CH];
   int perc [NUM_CH][NPER];
   logic [PER-1:0] firstpat [NUM_CH];

   always #2 clk = ~clk;

   dsx_pwm_dac #(
      .NUM_CH(NUM_CH), .COARSE_W(COARSE_W), .FRAC_W(FRAC_W), .CH_W(CH_W)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_en_i(wr_en),
      .wr_ch_i(wr_ch), .wr_data_i(wr_data), .pwm_o(pwm)
   );

   task automatic chk(input string req, input int act, input int exp);
      applied++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_sp(input int ch, input logic [SP_W-1:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_ch = CH_W'(ch); wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // enable, then sample nper periods; optional write at sample wr_at
   task automatic measure(input int nper, input int wr_at,
                          input int wr_c, input logic [SP_W-1:0] wr_v);
      for (int c = 0; c < NUM_CH; c++) begin
         sums[c] = 0;
         firstpat[c] = '0;
         for (int p = 0; p < NPER; p++) perc[c][p] = 0;
      end
      @(negedge clk);
      en = 1'b1;
      @(posedge clk);
      @(posedge clk);
      for (int s = 0; s < nper * PER; s++) begin
         @(negedge clk);
         for (int c = 0; c < NUM_CH; c++) begin
            if (pwm[c]) begin
               sums[c]++;
               perc[c][s / PER]++;
            end
            if (s < PER) firstpat[c][s] = pwm[c];
         end
         if (s == wr_at) begin
            wr_en = 1'b1; wr_ch = CH_W'(wr_c); wr_data = wr_v;
         end else begin
            wr_en = 1'b0;
         end
      end
      en = 1'b0;
      wr_en = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 outputs in reset", int'(pwm), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 outputs after reset", int'(pwm), 0);

      // round 1: channel i gets VEC[i]
      for (int c = 0; c < NUM_CH; c++) write_sp(c, VEC[c]);
      measure(NPER, -1, 0, '0);
      for (int c = 0; c < NUM_CH; c++)
         chk($sformatf("R4 ch%0d total high", c), sums[c], int'(VEC[c]));
      // R5: zero setpoint
      chk("R5 zero setpoint first period", perc[0][0], 0);
      // R2: coarse 5, no fraction -> counts 0..4 high
      chk("R2 pulse position ch1", int'(firstpat[1]), 16'h001F);
      // R3: fraction 0x80 on coarse 2
      chk("R3 period0 width", perc[2][0], 2);
      chk("R3 period1 width", perc[2][1], 3);
      chk("R3 period2 width", perc[2][2], 2);
      chk("R3 period3 width", perc[2][3], 3);
      // R6: coarse max, first carry in period 1
      chk("R6 period0 width", perc[3][0], PER - 1);
      chk("R6 saturated period1", perc[3][1], PER);
      // R8: disable forces outputs low
      @(negedge clk);
      @(negedge clk);
      chk("R8 outputs low after disable", int'(pwm), 0);

      // round 2: reversed assignment, checks accumulator restart (R8)
      for (int c = 0; c < NUM_CH; c++) write_sp(c, VEC[NUM_CH-1-c]);
      measure(NPER, -1, 0, '0);
      for (int c = 0; c < NUM_CH; c++)
         chk($sformatf("R4 R8 ch%0d total high rerun", c), sums[c],
             int'(VEC[NUM_CH-1-c]));
      repeat (3) @(negedge clk);

      // R7 and R10: mid-period write to ch0
      write_sp(0, 12'hA00);
      measure(2, 2, 0, 12'h300);
      chk("R7 current period unchanged", perc[0][0], 10);
      chk("R7 next period new width", perc[0][1], 3);
      chk("R10 other channel period0", perc[1][0], 10);
      chk("R10 other channel period1", perc[1][1], 10);
      repeat (3) @(negedge clk);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end
endmodule